// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block is a hardware sequencer that brings a video-processing power domain up or down when asked. It owns the domain's power-switch enable, its isolation control, a set of memory power-down controls, the domain reset and the domain clock enable. It steps through a fixed order of control changes and waits a set number of microseconds between them. All waits are measured with a microsecond tick derived from a cycles-per-microsecond parameter.

Two request inputs start a sequence, one toward on and one toward off. A variant input, sampled when a request is accepted, adds a third paired memory bank to the sequence. While a sequence runs, the block reports busy and a transitional power state. When it finishes, it raises a one-cycle done pulse and reports the settled state. Every control change is registered, and no step changes more than one control group.

Top module: `vpd_power_seq`

## Requirements
- R1: After reset the switch enable is 0, isolation is 1, every bit of `mem_pd_o` and `mem_aux_pd_o` is 1, the domain reset and clock enable are 0, busy and done are 0, and `pstate_o` is 0 (off).
- R2: Power-up first sets the switch enable. The first memory change follows `1 + PWR_US*CYC_PER_US` cycles later.
- R3: Memory bit value 1 means powered down. Paired bank k occupies `mem_pd_o[BANK_W*k+BANK_W-1 : BANK_W*k]`. Pair group g is bits `2g+1:2g` of `mem_pd_o`. Groups are handled in ascending g, one per step, and consecutive memory steps are `1 + MEM_US*CYC_PER_US` cycles apart.
- R4: After the paired groups, the `AUX_BITS` bits of `mem_aux_pd_o` change one at a time from bit 0 upward, with the same spacing as R3.
- R5: The step after the last auxiliary bit comes `1 + (MEM_US+TAIL_US)*CYC_PER_US` cycles after it, in both directions.
- R6: The power-up ending runs on four consecutive cycles: domain reset to 1, isolation to 0, domain reset to 0, clock enable to 1.
- R7: Power-down first sets isolation and waits `PWR_US` microseconds. It then sets the memory bits to 1 in the order and with the spacing of R3 to R5.
- R8: After the memories, power-down clears the switch enable. Clock enable clears `1 + CLKOFF_US*CYC_PER_US` cycles later.
- R9: With `ext_bank_i` = 1 at acceptance, the third bank (bank 2) is processed after bank 1. With 0 it is skipped and keeps its value. Changes of `ext_bank_i` during a sequence have no effect.
- R10: `pstate_o` encodes 0 off, 1 on, 2 powering up, 3 powering down. Busy rises, with state 2 or 3, on the cycle after a request is accepted. The first control change follows one cycle later. One cycle after the last control change, busy falls, done pulses for one cycle and the state settles to 0 or 1.
- R11: Requests that arrive while busy is 1 are ignored.
- R12: A request for the state already held sets done on the next cycle without busy or any control change. If both requests are high together, power-down wins.
- R13: At most one control group (switch, isolation, reset, clock, paired memory, auxiliary memory) changes in any cycle. A paired step changes at most two bits and an auxiliary step at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_on_i | input | 1 | Request to power the domain up |
| req_off_i | input | 1 | Request to power the domain down |
| ext_bank_i | input | 1 | Variant select: include the third paired bank |
| sw_on_o | output | 1 | Domain power-switch enable |
| iso_o | output | 1 | Isolation enable |
| rst_o | output | 1 | Domain reset, active high |
| clk_en_o | output | 1 | Domain clock enable |
| mem_pd_o | output | (BASE_BANKS+1)*BANK_W | Paired memory power-down bits |
| mem_aux_pd_o | output | AUX_BITS | Auxiliary memory power-down bits |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pstate_o | output | 2 | Power state |

## Verification
A request seen at one edge raises busy at that edge, and the first control change lands one edge later. Every later change follows the previous one after one cycle plus the programmed wait in microseconds times the cycles per microsecond. Done comes one cycle after the final change. The bench turns each accepted request into a timed list of expected output events, built from these spacings, and applies each event on its due cycle. It then compares every output with the expected state on every clock, sampling at the falling edge. Separate checks measure the switch-to-memory gap and the auxiliary-to-reset gap directly from the observed transitions.

// File: rtl/vpd_seq_pkg.sv
package vpd_seq_pkg;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_SW,
      ACT_ISO,
      ACT_RST_SET,
      ACT_RST_CLR,
      ACT_CLK,
      ACT_PAIR,
      ACT_ONE
   } act_e;

   typedef enum logic [1:0] {
      PS_OFF  = 2'd0,
      PS_ON   = 2'd1,
      PS_RISE = 2'd2,
      PS_FALL = 2'd3
   } pstate_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACT,
      ST_WAIT,
      ST_FIN
   } fsm_e;

   function automatic int max_of3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/vpd_seq_timer.sv
// Microsecond wait counter: a prescaler restarts on every load so a wait of
// N microseconds lasts exactly N*CYC_PER_US cycles.
module vpd_seq_timer #(
   parameter int CYC_PER_US = 125,
   parameter int US_W       = 16
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            load_i,
   input  logic [US_W-1:0] load_us_i,
   output logic            expire_o
);
   localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);

   logic [PRE_W-1:0] pre_q;
   logic [US_W-1:0]  rem_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q <= '0;
         rem_q <= '0;
      end else if (load_i) begin
         pre_q <= '0;
         rem_q <= load_us_i;
      end else if (rem_q != '0) begin
         if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            rem_q <= rem_q - US_W'(1);
         end else begin
            pre_q <= pre_q + PRE_W'(1);
         end
      end
   end

   assign expire_o = (rem_q == US_W'(1)) && (pre_q == PRE_LAST);

endmodule

// File: rtl/vpd_seq_plan.sv
// Step decoder: maps a step index and direction to one control action,
// its group index, the wait that follows it and whether it is the last.
module vpd_seq_plan
   import vpd_seq_pkg::*;
#(
   parameter int BASE_BANKS = 2,
   parameter int PAIRS      = 16,
   parameter int AUX_BITS   = 8,
   parameter int PWR_US     = 20,
   parameter int MEM_US     = 5,
   parameter int TAIL_US    = 20,
   parameter int CLKOFF_US  = 20000,
   parameter int IDX_W      = 6,
   parameter int GRP_W      = 6,
   parameter int US_W       = 16
) (
   input  logic [IDX_W-1:0] idx_i,
   input  logic             up_i,
   input  logic             ext_i,
   output act_e             act_o,
   output logic [GRP_W-1:0] grp_o,
   output logic [US_W-1:0]  wait_o,
   output logic             last_o
);
   int n_pair;
   int n_mem;
   int i_step;
   int m_off;

   always_comb begin
      n_pair = (BASE_BANKS + (ext_i ? 1 : 0)) * PAIRS;
      n_mem  = n_pair + AUX_BITS;
      i_step = int'(idx_i);
      m_off  = 0;
      act_o  = ACT_NONE;
      grp_o  = '0;
      wait_o = '0;
      last_o = 1'b0;
      if (i_step == 0) begin
         act_o  = up_i ? ACT_SW : ACT_ISO;
         wait_o = US_W'(PWR_US);
      end else if (i_step <= n_mem) begin
         m_off = i_step - 1;
         if (m_off < n_pair) begin
            act_o = ACT_PAIR;
            grp_o = GRP_W'(m_off);
         end else begin
            act_o = ACT_ONE;
            grp_o = GRP_W'(m_off - n_pair);
         end
         wait_o = (i_step == n_mem) ? US_W'(MEM_US + TAIL_US) : US_W'(MEM_US);
      end else begin
         m_off = i_step - n_mem - 1;
         if (up_i) begin
            case (m_off)
               0:       act_o = ACT_RST_SET;
               1:       act_o = ACT_ISO;
               2:       act_o = ACT_RST_CLR;
               3:       begin act_o = ACT_CLK; last_o = 1'b1; end
               default: last_o = 1'b1;
            endcase
         end else begin
            case (m_off)
               0:       begin act_o = ACT_SW; wait_o = US_W'(CLKOFF_US); end
               1:       begin act_o = ACT_CLK; last_o = 1'b1; end
               default: last_o = 1'b1;
            endcase
         end
      end
   end

endmodule

// File: rtl/vpd_seq_outreg.sv
// Registered domain controls; one action updates one control group.
module vpd_seq_outreg
   import vpd_seq_pkg::*;
#(
   parameter int NBANK    = 3,
   parameter int BANK_W   = 32,
   parameter int AUX_BITS = 8,
   parameter int GRP_W    = 6
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    apply_i,
   input  act_e                    act_i,
   input  logic [GRP_W-1:0]        grp_i,
   input  logic                    up_i,
   output logic                    sw_o,
   output logic                    iso_o,
   output logic                    rst_o,
   output logic                    clk_o,
   output logic [NBANK*BANK_W-1:0] pd_o,
   output logic [AUX_BITS-1:0]     aux_o
);
   localparam int NGRP = NBANK * BANK_W / 2;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sw_o  <= 1'b0;
         iso_o <= 1'b1;
         rst_o <= 1'b0;
         clk_o <= 1'b0;
      end else if (apply_i) begin
         case (act_i)
            ACT_SW:      sw_o  <= up_i;
            ACT_ISO:     iso_o <= ~up_i;
            ACT_RST_SET: rst_o <= 1'b1;
            ACT_RST_CLR: rst_o <= 1'b0;
            ACT_CLK:     clk_o <= up_i;
            default:     ;
         endcase
      end
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_pair
      logic [1:0] pair_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            pair_q <= 2'b11;
         else if (apply_i && (act_i == ACT_PAIR) && (grp_i == GRP_W'(g)))
            pair_q <= {2{~up_i}};
      end
      assign pd_o[2*g +: 2] = pair_q;
   end

   for (genvar a = 0; a < AUX_BITS; a++) begin : g_aux
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            bit_q <= 1'b1;
         else if (apply_i && (act_i == ACT_ONE) && (grp_i == GRP_W'(a)))
            bit_q <= ~up_i;
      end
      assign aux_o[a] = bit_q;
   end

endmodule

// File: rtl/vpd_power_seq.sv
module vpd_power_seq
   import vpd_seq_pkg::*;
#(
   parameter int CYC_PER_US = 125,
   parameter int BANK_W     = 32,
   parameter int BASE_BANKS = 2,
   parameter int AUX_BITS   = 8,
   parameter int PWR_US     = 20,
   parameter int MEM_US     = 5,
   parameter int TAIL_US    = 20,
   parameter int CLKOFF_US  = 20000
) (
   input  logic                                clk_i,
   input  logic                                rst_ni,
   input  logic                                req_on_i,
   input  logic                                req_off_i,
   input  logic                                ext_bank_i,
   output logic                                sw_on_o,
   output logic                                iso_o,
   output logic                                rst_o,
   output logic                                clk_en_o,
   output logic [(BASE_BANKS+1)*BANK_W-1:0]    mem_pd_o,
   output logic [AUX_BITS-1:0]                 mem_aux_pd_o,
   output logic                                busy_o,
   output logic                                done_o,
   output logic [1:0]                          pstate_o
);
   localparam int NBANK  = BASE_BANKS + 1;
   localparam int MEM_W  = NBANK * BANK_W;
   localparam int PAIRS  = BANK_W / 2;
   localparam int NGRP   = NBANK * PAIRS;
   localparam int GRP_W  = $clog2(((NGRP > AUX_BITS) ? NGRP : AUX_BITS) + 1);
   localparam int NSTEP  = 1 + NGRP + AUX_BITS + 4;
   localparam int IDX_W  = $clog2(NSTEP + 1);
   localparam int US_MAX = max_of3(CLKOFF_US, PWR_US, MEM_US + TAIL_US);
   localparam int US_W   = $clog2(US_MAX + 1) + 1;

   if (BANK_W < 2 || (BANK_W % 2) != 0) begin : g_bad_bank
      $error("BANK_W must be a positive even width");
   end
   if (CYC_PER_US < 1 || BASE_BANKS < 1 || AUX_BITS < 1) begin : g_bad_cfg
      $error("CYC_PER_US, BASE_BANKS and AUX_BITS must be at least 1");
   end
   if (PWR_US < 1 || MEM_US < 1 || CLKOFF_US < 1) begin : g_bad_wait
      $error("step waits must be at least one microsecond");
   end

   fsm_e             st_q;
   pstate_e          ps_q;
   logic [IDX_W-1:0] idx_q;
   logic             up_q;
   logic             ext_q;
   logic             busy_q;
   logic             done_q;

   act_e             step_act;
   logic [GRP_W-1:0] step_grp;
   logic [US_W-1:0]  step_wait;
   logic             step_last;
   logic             tmr_expire;
   logic             in_act;

   assign in_act = (st_q == ST_ACT);

   vpd_seq_plan #(
      .BASE_BANKS(BASE_BANKS), .PAIRS(PAIRS), .AUX_BITS(AUX_BITS),
      .PWR_US(PWR_US), .MEM_US(MEM_US), .TAIL_US(TAIL_US),
      .CLKOFF_US(CLKOFF_US), .IDX_W(IDX_W), .GRP_W(GRP_W), .US_W(US_W)
   ) u_plan (
      .idx_i  (idx_q),
      .up_i   (up_q),
      .ext_i  (ext_q),
      .act_o  (step_act),
      .grp_o  (step_grp),
      .wait_o (step_wait),
      .last_o (step_last)
   );

   vpd_seq_timer #(
      .CYC_PER_US(CYC_PER_US), .US_W(US_W)
   ) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (in_act),
      .load_us_i (step_wait),
      .expire_o  (tmr_expire)
   );

   vpd_seq_outreg #(
      .NBANK(NBANK), .BANK_W(BANK_W), .AUX_BITS(AUX_BITS), .GRP_W(GRP_W)
   ) u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .apply_i (in_act),
      .act_i   (step_act),
      .grp_i   (step_grp),
      .up_i    (up_q),
      .sw_o    (sw_on_o),
      .iso_o   (iso_o),
      .rst_o   (rst_o),
      .clk_o   (clk_en_o),
      .pd_o    (mem_pd_o),
      .aux_o   (mem_aux_pd_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         ps_q   <= PS_OFF;
         idx_q  <= '0;
         up_q   <= 1'b0;
         ext_q  <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (req_off_i) begin
                  if (ps_q == PS_OFF) begin
                     done_q <= 1'b1;
                  end else begin
                     up_q   <= 1'b0;
                     ext_q  <= ext_bank_i;
                     idx_q  <= '0;
                     busy_q <= 1'b1;
                     ps_q   <= PS_FALL;
                     st_q   <= ST_ACT;
                  end
               end else if (req_on_i) begin
                  if (ps_q == PS_ON) begin
                     done_q <= 1'b1;
                  end else begin
                     up_q   <= 1'b1;
                     ext_q  <= ext_bank_i;
                     idx_q  <= '0;
                     busy_q <= 1'b1;
                     ps_q   <= PS_RISE;
                     st_q   <= ST_ACT;
                  end
               end
            end
            ST_ACT: begin
               if (step_wait == '0) begin
                  if (step_last) st_q <= ST_FIN;
                  else           idx_q <= idx_q + IDX_W'(1);
               end else begin
                  st_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (tmr_expire) begin
                  if (step_last) begin
                     st_q <= ST_FIN;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                     st_q  <= ST_ACT;
                  end
               end
            end
            ST_FIN: begin
               done_q <= 1'b1;
               busy_q <= 1'b0;
               ps_q   <= up_q ? PS_ON : PS_OFF;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign pstate_o = ps_q;

endmodule

// File: rtl/vpd_power_seq_chk.sv
module vpd_power_seq_chk #(
   parameter int MEM_W = 96,
   parameter int AUX_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             sw_on_o,
   input logic             iso_o,
   input logic             rst_o,
   input logic             clk_en_o,
   input logic [MEM_W-1:0] mem_pd_o,
   input logic [AUX_W-1:0] mem_aux_pd_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [1:0]       pstate_o
);

   // R13: a single control group moves per cycle
   p_one_group_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({sw_on_o != $past(sw_on_o), iso_o != $past(iso_o),
                  rst_o != $past(rst_o), clk_en_o != $past(clk_en_o),
                  mem_pd_o != $past(mem_pd_o),
                  mem_aux_pd_o != $past(mem_aux_pd_o)}) <= 1);

   // R3: a paired step touches at most two bits
   p_pair_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(mem_pd_o ^ $past(mem_pd_o)) <= 2);

   // R4: auxiliary bits move one at a time
   p_aux_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(mem_aux_pd_o ^ $past(mem_aux_pd_o)) <= 1);

   // R2: auxiliary memories are only awake while the switch is on
   p_mem_powered_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_aux_pd_o != '1) |-> sw_on_o);

   // R7: with the switch off the domain stays isolated
   p_iso_when_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sw_on_o |-> iso_o);

   // R6: isolation is lifted only while the domain reset is held
   p_iso_drop_in_reset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(iso_o) |-> rst_o);

   // R6: domain reset pulses only inside a sequence
   p_rst_in_seq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_o |-> busy_o);

   // R10: done never overlaps busy
   p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   // R10: busy starts with a transitional state
   p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> pstate_o[1]);

   // R11: the state does not switch direction mid-sequence
   p_ignore_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> (!busy_o || pstate_o == $past(pstate_o)));

endmodule

bind vpd_power_seq vpd_power_seq_chk #(
   .MEM_W(MEM_W), .AUX_W(AUX_BITS)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .sw_on_o      (sw_on_o),
   .iso_o        (iso_o),
   .rst_o        (rst_o),
   .clk_en_o     (clk_en_o),
   .mem_pd_o     (mem_pd_o),
   .mem_aux_pd_o (mem_aux_pd_o),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .pstate_o     (pstate_o)
);

// File: tb/tb_vpd_power_seq.sv
`timescale 1ns/1ps
module tb_vpd_power_seq;

   localparam int D      = 2;
   localparam int W_PWR  = 20;
   localparam int W_MEM  = 5;
   localparam int W_TAIL = 20;
   localparam int W_OFF  = 300;
   localparam int BW     = 32;
   localparam int NBB    = 2;
   localparam int NAUX   = 8;
   localparam int MW     = (NBB + 1) * BW;

   localparam int EV_BEGIN = 1, EV_SW = 2, EV_ISO = 3, EV_RST = 4, EV_CLK = 5,
                  EV_PAIR = 6, EV_ONE = 7, EV_END = 8, EV_SAME = 9, EV_DCLR = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_on = 1'b0, req_off = 1'b0, ext = 1'b0;
   logic sw_on, iso, drst, clk_en, busy, done;
   logic [MW-1:0]   mem_pd;
   logic [NAUX-1:0] aux_pd;
   logic [1:0]      pstate;

   always #4 clk = ~clk;

   vpd_power_seq #(.CYC_PER_US(D), .CLKOFF_US(W_OFF)) dut (
      .clk_i(clk), .rst_ni(rst_n), .req_on_i(req_on), .req_off_i(req_off),
      .ext_bank_i(ext), .sw_on_o(sw_on), .iso_o(iso), .rst_o(drst),
      .clk_en_o(clk_en), .mem_pd_o(mem_pd), .mem_aux_pd_o(aux_pd),
      .busy_o(busy), .done_o(done), .pstate_o(pstate)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   string scen = "R1";

   // reference model state
   logic e_sw, e_iso, e_rst, e_clk, e_busy, e_done;
   logic [MW-1:0]   e_pd;
   logic [NAUX-1:0] e_aux;
   logic [1:0]      e_ps;
   int q_t[$], q_k[$], q_g[$], q_v[$];

   // transition marks
   logic p_sw, p_rst;
   logic [MW-1:0]   p_pd;
   logic [NAUX-1:0] p_aux;
   int t_sw, t_pd, t_aux, t_rst;

   task automatic chk(string tag, string what, logic [127:0] a, logic [127:0] e);
      n_chk++;
      if (a !== e) begin
         n_fail++;
         $display("FAIL %s %s (scenario %s) cycle %0d: actual %0h expected %0h",
                  tag, what, scen, cyc, a, e);
      end
   endtask

   task automatic push(int t, int k, int g, int v);
      q_t.push_back(t); q_k.push_back(k); q_g.push_back(g); q_v.push_back(v);
   endtask

   task automatic model_apply();
      while (q_t.size() > 0 && q_t[0] <= cyc) begin
         int k, g, v;
         void'(q_t.pop_front());
         k = q_k.pop_front(); g = q_g.pop_front(); v = q_v.pop_front();
         case (k)
            EV_BEGIN: begin e_busy = 1'b1; e_ps = 2'(v); end
            EV_SW:    e_sw  = v[0];
            EV_ISO:   e_iso = v[0];
            EV_RST:   e_rst = v[0];
            EV_CLK:   e_clk = v[0];
            EV_PAIR:  e_pd[2*g +: 2] = {2{v[0]}};
            EV_ONE:   e_aux[g] = v[0];
            EV_END:   begin e_done = 1'b1; e_busy = 1'b0; e_ps = 2'(v); end
            EV_SAME:  e_done = 1'b1;
            EV_DCLR:  e_done = 1'b0;
            default:  ;
         endcase
      end
   endtask

   // Expected timeline of one sequence accepted at the edge after cycle c
   task automatic sched(bit up, bit x, int c);
      int t, npair;
      npair = (NBB + (x ? 1 : 0)) * (BW / 2);
      push(c + 1, EV_BEGIN, 0, up ? 2 : 3);
      t = c + 2;
      push(t, up ? EV_SW : EV_ISO, 0, 1);
      t += 1 + W_PWR * D;
      for (int p = 0; p < npair; p++) begin
         push(t, EV_PAIR, p, up ? 0 : 1);
         t += 1 + W_MEM * D;
      end
      for (int a = 0; a < NAUX; a++) begin
         push(t, EV_ONE, a, up ? 0 : 1);
         t += 1 + ((a == NAUX - 1) ? (W_MEM + W_TAIL) : W_MEM) * D;
      end
      if (up) begin
         push(t, EV_RST, 0, 1); t++;
         push(t, EV_ISO, 0, 0); t++;
         push(t, EV_RST, 0, 0); t++;
         push(t, EV_CLK, 0, 1); t++;
      end else begin
         push(t, EV_SW, 0, 0); t += 1 + W_OFF * D;
         push(t, EV_CLK, 0, 0); t++;
      end
      push(t, EV_END, 0, up ? 1 : 0);
      push(t + 1, EV_DCLR, 0, 0);
   endtask

   task automatic model_req(bit on, bit off);
      if (!(on || off) || e_busy) return;
      if (off) begin
         if (e_ps == 2'd0) begin push(cyc + 1, EV_SAME, 0, 0); push(cyc + 2, EV_DCLR, 0, 0); end
         else sched(1'b0, ext, cyc);
      end else begin
         if (e_ps == 2'd1) begin push(cyc + 1, EV_SAME, 0, 0); push(cyc + 2, EV_DCLR, 0, 0); end
         else sched(1'b1, ext, cyc);
      end
   endtask

   task automatic run_cycle(bit on, bit off);
      model_apply();
      chk("R2", "switch", 128'(sw_on), 128'(e_sw));
      chk("R7", "isolation", 128'(iso), 128'(e_iso));
      chk("R6", "domain reset", 128'(drst), 128'(e_rst));
      chk("R8", "clock enable", 128'(clk_en), 128'(e_clk));
      chk("R3", "paired memory", 128'(mem_pd), 128'(e_pd));
      chk("R4", "aux memory", 128'(aux_pd), 128'(e_aux));
      chk("R10", "busy", 128'(busy), 128'(e_busy));
      chk("R10", "done", 128'(done), 128'(e_done));
      chk("R10", "state", 128'(pstate), 128'(e_ps));
      if (sw_on && !p_sw) t_sw = cyc;
      if (mem_pd != p_pd && t_pd < 0) t_pd = cyc;
      if (aux_pd != p_aux) t_aux = cyc;
      if (drst && !p_rst) t_rst = cyc;
      p_sw = sw_on; p_pd = mem_pd; p_aux = aux_pd; p_rst = drst;
      model_req(on, off);
      req_on = on; req_off = off;
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic run_idle();
      for (int i = 0; i < 20000 && (e_busy || q_t.size() > 0); i++) run_cycle(1'b0, 1'b0);
      run_cycle(1'b0, 1'b0);
   endtask

   task automatic clear_marks();
      t_sw = -1; t_pd = -1; t_aux = -1; t_rst = -1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual still running, expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      e_sw = 0; e_iso = 1; e_rst = 0; e_clk = 0; e_busy = 0; e_done = 0; e_ps = 0;
      e_pd = '1; e_aux = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      p_sw = sw_on; p_pd = mem_pd; p_aux = aux_pd; p_rst = drst;
      clear_marks();

      // R1: reset state
      chk("R1", "reset controls", 128'({sw_on, iso, drst, clk_en}), 128'(4'b0100));
      chk("R1", "reset memories", 128'({mem_pd, aux_pd}), {128{1'b1}} >> (128 - MW - NAUX));
      chk("R1", "reset status", 128'({busy, done, pstate}), 128'(0));
      repeat (3) run_cycle(1'b0, 1'b0);

      // Basic power-up
      scen = "R2"; ext = 1'b0; clear_marks();
      run_cycle(1'b1, 1'b0);
      run_idle();
      chk("R2", "switch to first memory gap", 128'(t_pd - t_sw), 128'(1 + W_PWR * D));
      chk("R5", "aux to reset gap", 128'(t_rst - t_aux), 128'(1 + (W_MEM + W_TAIL) * D));
      chk("R9", "bank 2 untouched in basic variant", 128'(mem_pd[MW-1 -: BW]), 128'(32'hFFFF_FFFF));
      chk("R10", "state on", 128'(pstate), 128'(1));

      // Request for the state already held
      scen = "R12";
      run_cycle(1'b1, 1'b0);
      chk("R12", "same-state done", 128'({done, busy}), 128'(2'b10));
      run_idle();

      // Basic power-down
      scen = "R7"; clear_marks();
      run_cycle(1'b0, 1'b1);
      run_idle();
      chk("R8", "off controls", 128'({sw_on, iso, clk_en}), 128'(3'b010));
      chk("R5", "aux to switch-off spacing seen", 128'(t_aux > 0), 128'(1));

      // Extended power-up with requests during the run
      scen = "R11"; ext = 1'b1;
      run_cycle(1'b1, 1'b0);
      ext = 1'b0;
      repeat (50) run_cycle(1'b0, 1'b0);
      run_cycle(1'b0, 1'b1);
      repeat (30) run_cycle(1'b0, 1'b0);
      run_cycle(1'b1, 1'b1);
      run_idle();
      chk("R9", "all banks powered in extended variant", 128'(mem_pd), 128'(0));
      chk("R11", "requests while busy ignored", 128'(pstate), 128'(1));

      // Both requests at once: off wins
      scen = "R12"; ext = 1'b1;
      run_cycle(1'b1, 1'b1);
      chk("R12", "off wins on simultaneous requests", 128'(pstate), 128'(3));
      run_idle();
      chk("R9", "extended power-down sets bank 2", 128'(mem_pd), {128{1'b1}} >> (128 - MW));

      // Off request while off
      run_cycle(1'b0, 1'b1);
      chk("R12", "same-state off done", 128'({done, busy, pstate}), 128'(4'b1000));
      run_idle();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule